// File: doc/BRIEF.md
# Dual-Port Word Memory with Selectable Read-During-Write Behaviour

This block stores 2048 words of 8 bits and offers two ports, A and B, that run on one shared clock. Each port has its own enable, write strobe, address, write data, output reset and registered read data. Each port can read or write on every cycle. A port reads a word and the word appears on that port's output register one cycle later.

A parameter per port sets what that port's output shows in a cycle in which the same port writes. The choices are: hold the last output, show the word that was stored before the write, or show the data being written. The block also compares the two ports on every cycle. It raises one flag when both ports write the same word. It raises a second flag when one port writes a word that the other port reads at the same moment. Both cases resolve to a fixed result, so the stored contents and the outputs stay defined.

Top module: `dpram_wmode`

## Requirements
- R1: A port with enable high, write strobe low and output reset low presents, one clock after the edge, the word stored at its address before that edge.
- R2: A port with enable low and output reset low keeps its output unchanged and writes nothing, even with its write strobe high.
- R3: With the port's mode set to hold (parameter value WM_NO_CHANGE, code 0), a write cycle stores the data and leaves that port's output unchanged.
- R4: With the port's mode set to old-data (WM_READ_FIRST, code 1), a write cycle stores the data and the output shows the word held at that address before the edge.
- R5: With the port's mode set to new-data (WM_WRITE_FIRST, code 2), a write cycle stores the data and the output shows that port's own write data.
- R6: An output reset high loads RST_VAL (default 0) into that port's output on the next edge, whatever the enable is. A write issued in the same cycle is still stored.
- R7: When both ports are enabled and write the same address, `coll_write` is high for the cycle after the edge and port A's data is the one stored. Outside this case `coll_write` is low.
- R8: When both ports are enabled on the same address and exactly one of them writes, `coll_rdw` is high for the cycle after the edge and the reading port shows the word stored before the edge. Outside this case `coll_rdw` is low.
- R9: Writes from the two ports to different addresses in one cycle both land, and neither flag is raised. Addresses 0 and 2047 behave like any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write strobe |
| srst_a | input | 1 | Port A synchronous output reset |
| addr_a | input | 11 | Port A word address |
| din_a | input | 8 | Port A write data |
| dout_a | output | 8 | Port A registered read data |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write strobe |
| srst_b | input | 1 | Port B synchronous output reset |
| addr_b | input | 11 | Port B word address |
| din_b | input | 8 | Port B write data |
| dout_b | output | 8 | Port B registered read data |
| coll_write | output | 1 | Both ports wrote the same address on the last edge |
| coll_rdw | output | 1 | One port wrote the address the other read on the last edge |

## Verification
Two copies of the block receive the same stimulus. One copy is built with hold mode on A and new-data mode on B, and the other with old-data mode on both ports. This way a single write cycle separates all three modes. The patterns used are:
- plain reads after preloading, which tell a registered read from a stale one;
- own-port writes, which tell the modes apart;
- writes issued with the enable low, followed by a read-back, which tell a blocked write from a leaked one;
- same-address double writes, which show which port wins and whether the flag is raised;
- cross-port write-and-read on one address in both directions, which shows whether the reader sees old data;
- output resets combined with writes, and accesses at addresses 0 and 2047.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    WM_NO_CHANGE   = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_WRITE_FIRST = 2'd2
  } wmode_e;
endpackage

// File: rtl/dpr_store.sv
module dpr_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] din_a,
  input  logic              wr_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] din_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Port B is applied first so that port A's store takes effect on a clash.
  always_ff @(posedge clk) begin
    if (wr_b) mem[addr_b] <= din_b;
    if (wr_a) mem[addr_a] <= din_a;
  end

  // Reads see the contents before the edge.
  assign rd_a = mem[addr_a];
  assign rd_b = mem[addr_b];
endmodule

// File: rtl/dpr_port_out.sv
module dpr_port_out #(
  parameter int              DATA_W  = 8,
  parameter dpr_pkg::wmode_e MODE    = dpr_pkg::WM_READ_FIRST,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              en,
  input  logic              we,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] dout
);
  function automatic logic [DATA_W-1:0] next_word(
    input logic              en_i,
    input logic              we_i,
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] stored,
    input logic [DATA_W-1:0] fresh
  );
    logic [DATA_W-1:0] r;
    if (!en_i)      r = cur;
    else if (!we_i) r = stored;
    else begin
      case (MODE)
        dpr_pkg::WM_NO_CHANGE:   r = cur;
        dpr_pkg::WM_WRITE_FIRST: r = fresh;
        default:                 r = stored;
      endcase
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (srst) dout <= RST_VAL;
    else      dout <= next_word(en, we, dout, rd_word, din);
  end
endmodule

// File: rtl/dpr_collide.sv
module dpr_collide #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              en_a,
  input  logic              we_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic              en_b,
  input  logic              we_b,
  input  logic [ADDR_W-1:0] addr_b,
  output logic              coll_write,
  output logic              coll_rdw
);
  // Returns {read-during-write, write-write}.
  function automatic logic [1:0] classify(
    input logic ea, input logic wa, input logic eb, input logic wb,
    input logic same
  );
    logic both;
    both = ea & eb & same;
    return {both & (wa ^ wb), both & wa & wb};
  endfunction

  logic [1:0] cls;
  assign cls = classify(en_a, we_a, en_b, we_b, addr_a == addr_b);

  always_ff @(posedge clk) begin
    coll_write <= cls[0];
    coll_rdw   <= cls[1];
  end
endmodule

// File: rtl/dpram_wmode.sv
module dpram_wmode #(
  parameter int              ADDR_W  = 11,
  parameter int              DATA_W  = 8,
  parameter dpr_pkg::wmode_e MODE_A  = dpr_pkg::WM_READ_FIRST,
  parameter dpr_pkg::wmode_e MODE_B  = dpr_pkg::WM_READ_FIRST,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              en_a,
  input  logic              we_a,
  input  logic              srst_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] din_a,
  output logic [DATA_W-1:0] dout_a,
  input  logic              en_b,
  input  logic              we_b,
  input  logic              srst_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] din_b,
  output logic [DATA_W-1:0] dout_b,
  output logic              coll_write,
  output logic              coll_rdw
);
  localparam int NPORT = 2;

  // Named internal events
  logic              wr_ev_a, wr_ev_b;
  logic [DATA_W-1:0] rd_word_a, rd_word_b;

  assign wr_ev_a = en_a & we_a;
  assign wr_ev_b = en_b & we_b;

  dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk),
    .wr_a(wr_ev_a), .addr_a(addr_a), .din_a(din_a),
    .wr_b(wr_ev_b), .addr_b(addr_b), .din_b(din_b),
    .rd_a(rd_word_a), .rd_b(rd_word_b)
  );

  logic [NPORT-1:0]  en_v, we_v, rs_v;
  logic [DATA_W-1:0] din_v  [NPORT];
  logic [DATA_W-1:0] rd_v   [NPORT];
  logic [DATA_W-1:0] dout_v [NPORT];

  assign en_v = {en_b, en_a};
  assign we_v = {we_b, we_a};
  assign rs_v = {srst_b, srst_a};
  assign din_v[0] = din_a;
  assign din_v[1] = din_b;
  assign rd_v[0]  = rd_word_a;
  assign rd_v[1]  = rd_word_b;

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
    localparam dpr_pkg::wmode_e PMODE = (gi == 0) ? MODE_A : MODE_B;
    dpr_port_out #(.DATA_W(DATA_W), .MODE(PMODE), .RST_VAL(RST_VAL)) u_out (
      .clk(clk), .srst(rs_v[gi]), .en(en_v[gi]), .we(we_v[gi]),
      .din(din_v[gi]), .rd_word(rd_v[gi]), .dout(dout_v[gi])
    );
  end

  assign dout_a = dout_v[0];
  assign dout_b = dout_v[1];

  dpr_collide #(.ADDR_W(ADDR_W)) u_coll (
    .clk(clk),
    .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
    .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
    .coll_write(coll_write), .coll_rdw(coll_rdw)
  );
endmodule

// File: rtl/dpram_wmode_chk.sv
module dpram_wmode_chk #(
  parameter int              ADDR_W  = 11,
  parameter int              DATA_W  = 8,
  parameter dpr_pkg::wmode_e MODE_A  = dpr_pkg::WM_READ_FIRST,
  parameter dpr_pkg::wmode_e MODE_B  = dpr_pkg::WM_READ_FIRST,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input logic              clk,
  input logic              en_a, we_a, srst_a,
  input logic [ADDR_W-1:0] addr_a,
  input logic [DATA_W-1:0] din_a,
  input logic [DATA_W-1:0] dout_a,
  input logic              en_b, we_b, srst_b,
  input logic [ADDR_W-1:0] addr_b,
  input logic [DATA_W-1:0] din_b,
  input logic [DATA_W-1:0] dout_b,
  input logic              coll_write, coll_rdw,
  input logic [DATA_W-1:0] rd_word_a, rd_word_b
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  logic [1:0]        en_v, we_v, rs_v;
  logic [DATA_W-1:0] din_v [2];
  logic [DATA_W-1:0] rd_v  [2];
  logic [DATA_W-1:0] out_v [2];
  assign en_v = {en_b, en_a};
  assign we_v = {we_b, we_a};
  assign rs_v = {srst_b, srst_a};
  assign din_v[0] = din_a;     assign din_v[1] = din_b;
  assign rd_v[0]  = rd_word_a; assign rd_v[1]  = rd_word_b;
  assign out_v[0] = dout_a;    assign out_v[1] = dout_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_chk
    localparam dpr_pkg::wmode_e PM = (gi == 0) ? MODE_A : MODE_B;

    p_read_r1: assert property (@(posedge clk) disable iff (!armed)
      (en_v[gi] && !we_v[gi] && !rs_v[gi]) |=> out_v[gi] == $past(rd_v[gi]));
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!armed)
      (!en_v[gi] && !rs_v[gi]) |=> $stable(out_v[gi]));
    p_srst_r6: assert property (@(posedge clk) disable iff (!armed)
      rs_v[gi] |=> out_v[gi] == RST_VAL);

    if (PM == dpr_pkg::WM_NO_CHANGE) begin : g_nc
      p_nc_hold_r3: assert property (@(posedge clk) disable iff (!armed)
        (en_v[gi] && we_v[gi] && !rs_v[gi]) |=> $stable(out_v[gi]));
    end else if (PM == dpr_pkg::WM_WRITE_FIRST) begin : g_wf
      p_wf_new_r5: assert property (@(posedge clk) disable iff (!armed)
        (en_v[gi] && we_v[gi] && !rs_v[gi]) |=> out_v[gi] == $past(din_v[gi]));
    end else begin : g_rf
      p_rf_old_r4: assert property (@(posedge clk) disable iff (!armed)
        (en_v[gi] && we_v[gi] && !rs_v[gi]) |=> out_v[gi] == $past(rd_v[gi]));
    end
  end

  p_ww_flag_r7: assert property (@(posedge clk) disable iff (!armed)
    (en_a && we_a && en_b && we_b && addr_a == addr_b) |=> coll_write);
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!armed)
    $onehot0({coll_write, coll_rdw}));
  p_rdw_flag_r8: assert property (@(posedge clk) disable iff (!armed)
    (en_a && en_b && (we_a != we_b) && addr_a == addr_b) |=> coll_rdw);
  p_quiet_r9: assert property (@(posedge clk) disable iff (!armed)
    (addr_a != addr_b) |=> !coll_write && !coll_rdw);
endmodule

bind dpram_wmode dpram_wmode_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_A(MODE_A), .MODE_B(MODE_B),
  .RST_VAL(RST_VAL)
) u_chk (.*);

// File: tb/tb_dpram_wmode.sv
`timescale 1ns/1ps
module tb_dpram_wmode;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        en_a = 0, we_a = 0, srst_a = 0, en_b = 0, we_b = 0, srst_b = 0;
  logic [10:0] addr_a = '0, addr_b = '0;
  logic [7:0]  din_a = '0, din_b = '0;
  logic [7:0]  o_nc_a, o_wf_b, o_rf_a, o_rf_b;
  logic        cw0, cr0, cw1, cr1;

  dpram_wmode #(.MODE_A(dpr_pkg::WM_NO_CHANGE), .MODE_B(dpr_pkg::WM_WRITE_FIRST)) dut (
    .clk(clk), .en_a(en_a), .we_a(we_a), .srst_a(srst_a), .addr_a(addr_a),
    .din_a(din_a), .dout_a(o_nc_a), .en_b(en_b), .we_b(we_b), .srst_b(srst_b),
    .addr_b(addr_b), .din_b(din_b), .dout_b(o_wf_b),
    .coll_write(cw0), .coll_rdw(cr0));

  dpram_wmode #(.MODE_A(dpr_pkg::WM_READ_FIRST), .MODE_B(dpr_pkg::WM_READ_FIRST)) dut_rf (
    .clk(clk), .en_a(en_a), .we_a(we_a), .srst_a(srst_a), .addr_a(addr_a),
    .din_a(din_a), .dout_a(o_rf_a), .en_b(en_b), .we_b(we_b), .srst_b(srst_b),
    .addr_b(addr_b), .din_b(din_b), .dout_b(o_rf_b),
    .coll_write(cw1), .coll_rdw(cr1));

  typedef struct {
    logic [7:0] d [4];
    logic       cw;
    logic       cr;
    string      tag;
  } item_t;

  item_t      q[$];
  logic [7:0] mdl [2048];
  logic [7:0] mo  [4];   // 0: hold A, 1: new-data B, 2: old-data A, 3: old-data B
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [7:0] mnext(int mode, logic rs, logic en, logic we,
                                       logic [7:0] cur, logic [7:0] old, logic [7:0] nw);
    if (rs) return 8'h00;
    if (!en) return cur;
    if (!we) return old;
    if (mode == 0) return cur;
    if (mode == 2) return nw;
    return old;
  endfunction

  task automatic step(input logic ea, wa, ra, input logic [10:0] aa, input logic [7:0] da,
                      input logic eb, wb, rb, input logic [10:0] ab, input logic [7:0] db,
                      input string tag);
    item_t it;
    logic [7:0] olda, oldb;
    @(negedge clk);
    en_a = ea; we_a = wa; srst_a = ra; addr_a = aa; din_a = da;
    en_b = eb; we_b = wb; srst_b = rb; addr_b = ab; din_b = db;
    olda = mdl[aa]; oldb = mdl[ab];
    mo[0] = mnext(0, ra, ea, wa, mo[0], olda, da);
    mo[1] = mnext(2, rb, eb, wb, mo[1], oldb, db);
    mo[2] = mnext(1, ra, ea, wa, mo[2], olda, da);
    mo[3] = mnext(1, rb, eb, wb, mo[3], oldb, db);
    it.d = mo;
    it.cw = ea && eb && wa && wb && (aa == ab);
    it.cr = ea && eb && (wa != wb) && (aa == ab);
    it.tag = tag;
    if (eb && wb) mdl[ab] = db;
    if (ea && wa) mdl[aa] = da;   // port A wins
    @(posedge clk);
    #1 q.push_back(it);
  endtask

  task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      cmp(it.tag, "hold-mode dout_a",     o_nc_a, it.d[0]);
      cmp(it.tag, "new-data dout_b",      o_wf_b, it.d[1]);
      cmp(it.tag, "old-data dout_a",      o_rf_a, it.d[2]);
      cmp(it.tag, "old-data dout_b",      o_rf_b, it.d[3]);
      cmp(it.tag, "coll_write",           {7'd0, cw0}, {7'd0, it.cw});
      cmp(it.tag, "coll_rdw",             {7'd0, cr0}, {7'd0, it.cr});
      cmp(it.tag, "coll_write copy",      {7'd0, cw1}, {7'd0, it.cw});
      cmp(it.tag, "coll_rdw copy",        {7'd0, cr1}, {7'd0, it.cr});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) mo[i] = 8'h00;
    // R6: reset state, outputs to zero with enables low
    step(0,0,1, 11'd0,8'h00, 0,0,1, 11'd0,8'h00, "R6 reset");
    // R6/R9: preload under output reset, different addresses, writes still land
    step(1,1,1, 11'd5,8'h11,    1,1,1, 11'd9,8'h22,    "R6 R9 preload");
    step(1,1,1, 11'd0,8'h0F,    1,1,1, 11'd2047,8'hF7, "R9 preload edges");
    step(1,1,1, 11'd100,8'h64,  1,1,1, 11'd200,8'hC8,  "R9 preload");
    // R1: plain reads
    step(1,0,0, 11'd5,8'h00,    1,0,0, 11'd9,8'h00,    "R1 read");
    step(1,0,0, 11'd2047,8'h00, 1,0,0, 11'd0,8'h00,    "R1 R9 read edges");
    // R3/R4: A writes, hold vs old-data
    step(1,1,0, 11'd5,8'h33,    1,0,0, 11'd9,8'h00,    "R3 R4 write A");
    // R5/R4: B writes, new-data vs old-data
    step(1,0,0, 11'd5,8'h00,    1,1,0, 11'd9,8'h44,    "R5 R4 write B");
    // R2: disabled writes ignored, outputs hold
    step(0,1,0, 11'd5,8'hEE,    0,1,0, 11'd9,8'hDD,    "R2 disabled");
    step(1,0,0, 11'd9,8'h00,    1,0,0, 11'd5,8'h00,    "R2 readback");
    // R7: same-address double write, A wins
    step(1,1,0, 11'd100,8'hA1,  1,1,0, 11'd100,8'hB2,  "R7 clash");
    step(1,0,0, 11'd100,8'h00,  1,0,0, 11'd100,8'h00,  "R7 winner readback");
    // R8: A writes, B reads same word; then reverse
    step(1,1,0, 11'd200,8'h5A,  1,0,0, 11'd200,8'h00,  "R8 A writes B reads");
    step(1,0,0, 11'd0,8'h00,    1,1,0, 11'd0,8'h3C,    "R8 B writes A reads");
    step(1,0,0, 11'd200,8'h00,  1,0,0, 11'd0,8'h00,    "R8 readback");
    // R6: reset on one port only, enable low, while other port writes
    step(0,0,1, 11'd5,8'h00,    1,1,0, 11'd2047,8'h99, "R6 one-port reset");
    step(1,1,1, 11'd1,8'h77,    0,0,0, 11'd0,8'h00,    "R6 write under reset");
    step(1,0,0, 11'd1,8'h00,    1,0,0, 11'd2047,8'h00, "R6 R9 readback");
    // R9: sweep of distinct-address writes and reads
    for (int i = 0; i < 16; i++)
      step(1,1,0, 11'(i*37+300),8'(i*7+1), 1,1,0, 11'(i*53+1100),8'(i*11+2), "R9 sweep write");
    for (int i = 0; i < 16; i++)
      step(1,0,0, 11'(i*53+1100),8'h00, 1,0,0, 11'(i*37+300),8'h00, "R9 R1 sweep read");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule